// File: doc/BRIEF.md
# Row-Group Time-Integrating Track Filter

This block picks out straight, high-transverse-momentum particle tracks from the row-wise hit pattern of a gas pixel detector. On every bunch crossing it receives one bit per row. Each bit is the common OR of all pixels in that row. A track that is almost radial drifts onto a narrow band of rows for the full drift time. A curved, low-momentum track sweeps across many rows and stays only briefly on any one of them.

For each row, the filter first forms a frame bit. The frame bit is the OR of that row and the rows above it, up to a fixed group size. The frame bits then pass through a fixed-depth delay pipeline. A moving sum then counts, per row, how many of the last few crossings had the frame bit set. A row fires for exactly one cycle on the crossing where its count rises from one below the threshold to the threshold.

The outputs are:
- the full vector of firing rows;
- a valid flag;
- the lowest firing row, used as the track coordinate;
- the crossing number of the sample that completed the count.

Top module: `rowgroup_track_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, every delay stage, window and sum clears, and all outputs read zero on the following cycle. No trigger is caused by samples presented before a reset.
- R2: The frame bit of row r is the OR of `row_hit[r]` through `row_hit[r+GROUP-1]` (GROUP = 8). Rows past the highest index count as zero, so a hit on row h lights frames max(0,h-7) through h.
- R3: Each row's count is the number of set frame bits among its last WIN = 8 integrated samples. This holds whether or not those samples were consecutive.
- R4: `trig_vec[r]` is 1 for exactly one cycle when row r's count goes from 6 to 7 (THR = 7). A count that stays at 7 or 8 does not fire again.
- R5: A sample held on `row_hit` during crossing s affects `trig_vec` during crossing s+PIPE+1, where PIPE = 4. Crossing 0 is the first cycle with `rst_n` high.
- R6: `trig_bx` carries the crossing number s of the sample that completed the count. The crossing number counts from 0 after reset and wraps modulo 2^12. `trig_bx` reads 0 when nothing fires.
- R7: `trig_valid` is 1 exactly when any bit of `trig_vec` is 1. `trig_row` is the lowest firing row index, and reads 0 when nothing fires.
- R8: A hit that moves 4 rows per crossing, as a curved track does, never produces a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock, one edge per bunch crossing |
| rst_n | input | 1 | Synchronous active-low reset |
| row_hit | input | N_ROWS (128) | Per-row common-OR hit bit of the current crossing |
| trig_vec | output | N_ROWS (128) | Rows firing this cycle |
| trig_valid | output | 1 | At least one row fires |
| trig_row | output | $clog2(N_ROWS) (7) | Lowest firing row |
| trig_bx | output | BX_W (12) | Crossing number of the sample that completed the count |

## Verification
The bench targets the threshold edge. A seven-hit run followed by a gap and another hit, and a twelve-crossing track, must each fire only once; a level-sensitive comparator would fire again on every crossing the count stays high. A run of six hits, a gap and one more hit must fire, which catches a design that counts only consecutive hits. A run of six hits alone must stay silent, which catches an off-by-one threshold. Tracks on rows 2 and 127 expose a group that wraps around the array or reaches downward. A run that straddles crossing 4095 and a reset in the middle of a track catch a crossing counter that saturates or is misaligned by the pipeline, and a window that survives reset.

// File: rtl/rtf_pkg.sv
// Package: default geometry and timing of the row-group track filter.
// Assumes: consumers derive all widths from these values via parameters.
package rtf_pkg;
    localparam int unsigned ROWS_DEF  = 128;  // rows in the array
    localparam int unsigned GROUP_DEF = 8;    // rows ORed into one frame bit
    localparam int unsigned WIN_DEF   = 8;    // crossings in the moving sum
    localparam int unsigned PIPE_DEF  = 4;    // frame delay before integration
    localparam int unsigned THR_DEF   = 7;    // count that must be reached
    localparam int unsigned BXW_DEF   = 12;   // crossing-number width

    // Bits needed to hold values 0..maxval.
    function automatic int unsigned count_width(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction
endpackage

// File: rtl/rtf_frame_builder.sv
// Module: rtf_frame_builder
// Builds one frame bit per row as the OR of that row and the GROUP-1 rows
// above it. Rows beyond the top of the array are treated as zero.
// Assumes: GROUP >= 2; purely combinational.
module rtf_frame_builder #(
    parameter int unsigned N_ROWS = rtf_pkg::ROWS_DEF,
    parameter int unsigned GROUP  = rtf_pkg::GROUP_DEF
) (
    input  logic [N_ROWS-1:0] row_hit,
    output logic [N_ROWS-1:0] frame
);
    localparam int unsigned PAD_W = N_ROWS + GROUP - 1;

    logic [PAD_W-1:0] padded;

    // Zero-extend above the top row so edge groups see absent rows as empty.
    assign padded = {{(GROUP-1){1'b0}}, row_hit};

    for (genvar r = 0; r < N_ROWS; r++) begin : g_grp
        // One group OR per row.
        assign frame[r] = |padded[r +: GROUP];
    end
endmodule

// File: rtl/rtf_sample_delay.sv
// Module: rtf_sample_delay
// A DEPTH-stage register pipeline for a WIDTH-bit word; q is d delayed by
// DEPTH clock edges. Clears on synchronous active-low reset.
// Assumes: DEPTH >= 1.
module rtf_sample_delay #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = rtf_pkg::PIPE_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [DEPTH];

    // Shift the word one stage per crossing; clear all stages on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < int'(DEPTH); i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[DEPTH-1];
endmodule

// File: rtl/rtf_row_integrator.sv
// Module: rtf_row_integrator
// Moving sum of the last WIN frame samples of one row, kept as a shift
// window plus a running count (add newest, drop oldest). fire is high in
// the cycle whose edge moves the count from THR-1 to THR.
// Assumes: WIN >= 2, 1 <= THR <= WIN.
module rtf_row_integrator #(
    parameter int unsigned WIN = rtf_pkg::WIN_DEF,
    parameter int unsigned THR = rtf_pkg::THR_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    output logic fire
);
    localparam int unsigned SUM_W = rtf_pkg::count_width(WIN);
    localparam logic [SUM_W-1:0] AT_THR  = SUM_W'(THR);
    localparam logic [SUM_W-1:0] BELOW   = SUM_W'(THR - 1);
    localparam logic [SUM_W-1:0] SUM_MAX = SUM_W'(WIN);

    logic [WIN-1:0]   win;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] sum_nxt;

    // Next count: add the entering sample, subtract the leaving one.
    assign sum_nxt = sum + SUM_W'(sample) - SUM_W'(win[WIN-1]);

    // Fire only on the upward step onto the threshold.
    assign fire = (sum == BELOW) && (sum_nxt == AT_THR);

    // Advance the window and the running count each crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= '0;
            sum <= '0;
        end else begin
            win <= {win[WIN-2:0], sample};
            sum <= sum_nxt;
        end
    end

    p_sum_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sum <= SUM_MAX)
        else $error("count above window length");

    p_sum_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sum) == $countones(win))
        else $error("running count disagrees with window contents");

    p_sum_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (sum == $past(sum)) || (sum == $past(sum) + 1'b1)
                  || (sum == $past(sum) - 1'b1))
        else $error("count moved by more than one");
endmodule

// File: rtl/rtf_trig_encoder.sv
// Module: rtf_trig_encoder
// Registers the per-row fire vector, a valid flag, the lowest firing row
// and the crossing tag of the sample being integrated. Outputs are zero
// when nothing fires.
// Assumes: bx_tag is aligned with the samples producing fire_vec.
module rtf_trig_encoder #(
    parameter int unsigned N_ROWS = rtf_pkg::ROWS_DEF,
    parameter int unsigned BX_W   = rtf_pkg::BXW_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_ROWS-1:0]         fire_vec,
    input  logic [BX_W-1:0]           bx_tag,
    output logic [N_ROWS-1:0]         trig_vec,
    output logic                      trig_valid,
    output logic [$clog2(N_ROWS)-1:0] trig_row,
    output logic [BX_W-1:0]           trig_bx
);
    localparam int unsigned ROW_W = $clog2(N_ROWS);
    localparam logic [N_ROWS-1:0] ONE = {{(N_ROWS-1){1'b0}}, 1'b1};

    logic             any_fire;
    logic [ROW_W-1:0] low_row;

    // Priority pick of the lowest firing row.
    always_comb begin
        low_row = '0;
        for (int i = int'(N_ROWS) - 1; i >= 0; i--) begin
            if (fire_vec[i]) low_row = ROW_W'(i);
        end
    end

    assign any_fire = |fire_vec;

    // Capture this crossing's trigger report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_vec   <= '0;
            trig_valid <= 1'b0;
            trig_row   <= '0;
            trig_bx    <= '0;
        end else begin
            trig_vec   <= fire_vec;
            trig_valid <= any_fire;
            trig_row   <= any_fire ? low_row : '0;
            trig_bx    <= any_fire ? bx_tag : '0;
        end
    end

    p_row_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> trig_vec[trig_row])
        else $error("reported row is not firing");

    p_row_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> ((trig_vec & ((ONE << trig_row) - ONE)) == '0))
        else $error("a lower row fires than the one reported");

    p_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((trig_vec & $past(trig_vec)) == '0))
        else $error("a row fired on two consecutive crossings");
endmodule

// File: rtl/rowgroup_track_filter.sv
// Module: rowgroup_track_filter (top)
// Flags straight tracks: group OR across rows, PIPE-crossing delay,
// per-row moving sum over WIN crossings, one-cycle fire on THR-1 -> THR,
// and a registered report with lowest row and crossing number.
// Assumes: one clock edge per bunch crossing; synchronous active-low reset.
module rowgroup_track_filter #(
    parameter int unsigned N_ROWS = rtf_pkg::ROWS_DEF,
    parameter int unsigned GROUP  = rtf_pkg::GROUP_DEF,
    parameter int unsigned WIN    = rtf_pkg::WIN_DEF,
    parameter int unsigned PIPE   = rtf_pkg::PIPE_DEF,
    parameter int unsigned THR    = rtf_pkg::THR_DEF,
    parameter int unsigned BX_W   = rtf_pkg::BXW_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_ROWS-1:0]         row_hit,
    output logic [N_ROWS-1:0]         trig_vec,
    output logic                      trig_valid,
    output logic [$clog2(N_ROWS)-1:0] trig_row,
    output logic [BX_W-1:0]           trig_bx
);
    logic [BX_W-1:0]   bx_cnt;
    logic [BX_W-1:0]   bx_d;
    logic [N_ROWS-1:0] frame;
    logic [N_ROWS-1:0] frame_d;
    logic [N_ROWS-1:0] fire_vec;

    // Number the crossings from zero after reset, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) bx_cnt <= '0;
        else        bx_cnt <= bx_cnt + 1'b1;
    end

    rtf_frame_builder #(.N_ROWS(N_ROWS), .GROUP(GROUP)) u_frame (
        .row_hit (row_hit),
        .frame   (frame)
    );

    rtf_sample_delay #(.WIDTH(N_ROWS), .DEPTH(PIPE)) u_frame_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (frame),
        .q     (frame_d)
    );

    rtf_sample_delay #(.WIDTH(BX_W), .DEPTH(PIPE)) u_bx_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bx_cnt),
        .q     (bx_d)
    );

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        rtf_row_integrator #(.WIN(WIN), .THR(THR)) u_integ (
            .clk    (clk),
            .rst_n  (rst_n),
            .sample (frame_d[r]),
            .fire   (fire_vec[r])
        );
    end

    rtf_trig_encoder #(.N_ROWS(N_ROWS), .BX_W(BX_W)) u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_vec   (fire_vec),
        .bx_tag     (bx_d),
        .trig_vec   (trig_vec),
        .trig_valid (trig_valid),
        .trig_row   (trig_row),
        .trig_bx    (trig_bx)
    );

    p_bx_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> bx_cnt == $past(bx_cnt) + 1'b1)
        else $error("crossing counter skipped");

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!trig_valid && trig_vec == '0 && trig_bx == '0))
        else $error("trigger present right after reset");
endmodule

// File: tb/rowgroup_track_filter_bench.sv
// Scoreboard bench: the driver models each crossing from the requirements
// and queues the expected report; the monitor pops and compares it when due.
module rowgroup_track_filter_bench;
    localparam int NR = 128, GR = 8, WN = 8, PD = 4, TH = 7, BXW = 12;
    localparam int RW = $clog2(NR);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [NR-1:0] row_hit = '0;
    logic [NR-1:0] trig_vec;
    logic          trig_valid;
    logic [RW-1:0] trig_row;
    logic [BXW-1:0] trig_bx;

    rowgroup_track_filter u_rowgroup_track_filter (
        .clk(clk), .rst_n(rst_n), .row_hit(row_hit),
        .trig_vec(trig_vec), .trig_valid(trig_valid),
        .trig_row(trig_row), .trig_bx(trig_bx)
    );

    typedef struct {
        int            due;
        logic [NR-1:0] vec;
        int            row;
        int            bx;
    } exp_t;

    exp_t          sb[$];
    int            n_checks = 0, n_fail = 0;
    int            edge_n = 0, samp = 0;
    logic [WN-1:0] mwin [NR];
    int            msum [NR];
    int            pulses = 0, last_row = -1, last_bx = -1, last_edge = -1;
    logic [NR-1:0] last_vec = '0;

    task automatic chk(input string req, input string what,
                       input logic [NR-1:0] act, input logic [NR-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) edge_n <= 0;
        else        edge_n <= edge_n + 1;
    end

    // Monitor: compare the queued expectation that falls due this cycle.
    always @(negedge clk) begin
        if (rst_n && edge_n > 0) begin
            if (trig_valid) begin
                pulses++;
                last_row  = int'(trig_row);
                last_bx   = int'(trig_bx);
                last_edge = edge_n - 1;
                last_vec  = trig_vec;
            end
            if (sb.size() > 0 && sb[0].due == edge_n - 1) begin
                exp_t e;
                e = sb.pop_front();
                chk("R4", "trig_vec", trig_vec, e.vec);
                chk("R7", "trig_valid", NR'(trig_valid), NR'(e.vec != '0));
                chk("R7", "trig_row", NR'(trig_row), NR'(e.row));
                chk("R6", "trig_bx", NR'(trig_bx), NR'(e.bx));
            end else begin
                chk("R5", "idle trig_vec", trig_vec, '0);
            end
        end
    end

    // Driver: present one crossing and queue its expected report (R2, R3).
    task automatic drive(input logic [NR-1:0] hits);
        exp_t          e;
        logic [NR-1:0] fr;
        int            old;
        fr = '0;
        for (int r = 0; r < NR; r++)
            for (int k = 0; k < GR; k++)
                if (r + k < NR) fr[r] = fr[r] | hits[r+k];
        e.vec = '0;
        for (int r = 0; r < NR; r++) begin
            old = msum[r];
            mwin[r] = {mwin[r][WN-2:0], fr[r]};
            msum[r] = $countones(mwin[r]);
            if (old == TH - 1 && msum[r] == TH) e.vec[r] = 1'b1;
        end
        e.row = 0;
        for (int r = NR - 1; r >= 0; r--) if (e.vec[r]) e.row = r;
        e.bx  = (e.vec != '0) ? (samp % (1 << BXW)) : 0;
        e.due = samp + PD;
        sb.push_back(e);
        row_hit = hits;
        samp++;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive('0);
    endtask

    task automatic drain();
        idle(WN + PD + 3);
    endtask

    task automatic one_row(input int row, input int len);
        logic [NR-1:0] h;
        h = '0;
        h[row] = 1'b1;
        for (int i = 0; i < len; i++) drive(h);
    endtask

    // Reset for a few edges, check the cleared outputs (R1), restart the model.
    task automatic do_reset();
        rst_n   = 1'b0;
        row_hit = '0;
        repeat (3) @(negedge clk);
        chk("R1", "reset trig_vec", trig_vec, '0);
        chk("R1", "reset trig_valid", NR'(trig_valid), '0);
        chk("R1", "reset trig_row", NR'(trig_row), '0);
        chk("R1", "reset trig_bx", NR'(trig_bx), '0);
        sb.delete();
        for (int r = 0; r < NR; r++) begin
            mwin[r] = '0;
            msum[r] = 0;
        end
        samp  = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R5 watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int base, s0;
        logic [NR-1:0] h;
        @(negedge clk);
        do_reset();

        // Straight track on row 40: rows 33..40 fire (R2), latency (R5), tag (R6).
        idle(3);
        base = pulses; s0 = samp;
        one_row(40, 8); drain();
        chk("R4", "straight track pulses", NR'(pulses - base), NR'(1));
        chk("R2", "group rows lit", last_vec, {{(NR-8){1'b0}}, 8'hFF} << 33);
        chk("R5", "trigger edge", NR'(last_edge), NR'(s0 + 6 + PD));
        chk("R6", "trigger crossing", NR'(last_bx), NR'(s0 + 6));

        // Long track: the count stays at 8, so there is one pulse only (R4).
        base = pulses;
        one_row(60, 12); drain();
        chk("R4", "level does not retrigger", NR'(pulses - base), NR'(1));

        // Seven hits, a gap, one more hit: the count holds at 7 (R4).
        base = pulses;
        one_row(70, 7); idle(1); one_row(70, 1); drain();
        chk("R4", "seven-gap-one pulses", NR'(pulses - base), NR'(1));

        // Curved track moving 4 rows per crossing: silent (R8).
        base = pulses;
        for (int i = 0; i < 12; i++) begin
            h = '0; h[20 + 4*i] = 1'b1; drive(h);
        end
        drain();
        chk("R8", "curved track pulses", NR'(pulses - base), NR'(0));

        // Six hits, gap, one hit: non-consecutive count reaches 7 (R3).
        base = pulses; s0 = samp;
        one_row(90, 6); idle(1); one_row(90, 1); drain();
        chk("R3", "gapped pulses", NR'(pulses - base), NR'(1));
        chk("R6", "gapped crossing", NR'(last_bx), NR'(s0 + 7));

        // Six hits alone stay below threshold (R3).
        base = pulses;
        one_row(100, 6); drain();
        chk("R3", "six hits pulses", NR'(pulses - base), NR'(0));

        // Two tracks at once: lowest row of both groups reported (R7).
        h = '0; h[10] = 1'b1; h[80] = 1'b1;
        for (int i = 0; i < 8; i++) drive(h);
        drain();
        chk("R7", "two-track lowest row", NR'(last_row), NR'(3));
        chk("R7", "two-track row count", NR'($countones(last_vec)), NR'(16));

        // Array edges (R2).
        one_row(2, 8); drain();
        chk("R2", "bottom edge row", NR'(last_row), NR'(0));
        chk("R2", "bottom edge count", NR'($countones(last_vec)), NR'(3));
        one_row(127, 8); drain();
        chk("R2", "top edge row", NR'(last_row), NR'(120));
        chk("R2", "top edge count", NR'($countones(last_vec)), NR'(8));

        // Reset in mid-track clears the window (R1).
        one_row(30, 5);
        do_reset();
        base = pulses;
        one_row(30, 3); drain();
        chk("R1", "no trigger after reset", NR'(pulses - base), NR'(0));

        // Sparse random hits, compared by the scoreboard.
        for (int i = 0; i < 300; i++) begin
            h = '0;
            for (int k = 0; k < 4; k++) h[$urandom_range(NR-1)] = ($urandom_range(3) == 0);
            if (i % 40 < 9) h[(i / 40) * 15 + 5] = 1'b1;
            drive(h);
        end
        drain();

        // Crossing counter wraps: 7th hit lands on crossing 4096 -> 0 (R6).
        idle(4090 - samp);
        s0 = samp;
        one_row(50, 8); drain();
        chk("R6", "wrapped crossing", NR'(last_bx), NR'((s0 + 6) % 4096));
        chk("R5", "wrapped edge", NR'(last_edge), NR'(s0 + 6 + PD));

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule